// File: doc/BRIEF.md
# Multiplexed Bus Address Demultiplexer

This block sits between a processor whose bus shares the low address byte with the data byte and a memory or I/O subsystem that needs a separate, steady address bus and a separate data bus. Each bus cycle has four clock states. In the first state, T1, the processor raises its address latch enable. It places the low address byte on the shared lines, the middle byte on dedicated lines, and the top nibble on lines that later carry status. The block captures the low byte and the top nibble on that clock edge. It holds them until the next latch enable. The middle byte is routed straight through.

After T1 the block tracks states T2 to T4. It uses them to drive a data-enable output and a transfer-direction output, which steer the shared lines. On a read, the memory data is driven back onto the processor side. On a write, the shared-line byte is forwarded to the memory side. It also decodes the processor's active-low read and write pins, together with the memory/IO select, into separate active-low strobes for memory and for I/O.

Bus timing is fixed by the processor. There is no valid/ready handshake and no back-pressure: a slow target would need wait states, which are not part of this block.

Top module: `mux_bus_demux`

## Requirements
- R1: While reset is asserted, and after its release until the first latch enable, `addr[7:0]` and `addr[19:16]` are 0, `den` is 0, `dt_tx` is 0, and `ad_oe` and `mem_d_oe` are 0.
- R2: On a rising clock edge with `ale`=1, `addr[7:0]` takes `ad_i` and `addr[19:16]` takes `a_hi_st`. The new values are visible from that edge on, so the address 70C12H shows as `addr`=70C12H in T2.
- R3: On an edge with `ale`=0, `addr[7:0]` and `addr[19:16]` keep their value, whatever `ad_i` and `a_hi_st` carry. This includes the status value on `a_hi_st` and the data on `ad_i` during T2 to T4.
- R4: `addr[15:8]` equals `a_mid` combinationally, with no register.
- R5: `cyc_wr` is sampled with `ale`. In a read cycle (`cyc_wr`=0), `den`=1 in T2 and T3, `den`=0 in T4, and `dt_tx`=0, which means receive.
- R6: In a write cycle (`cyc_wr`=1), `den`=1 in T2, T3 and T4, and `dt_tx`=1, which means transmit.
- R7: During a read cycle with `den`=1, `ad_oe`=1, `ad_o` equals `mem_d_i`, and `mem_d_oe`=0.
- R8: During a write cycle with `den`=1, `mem_d_oe`=1, `mem_d_o` equals `ad_i`, and `ad_oe`=0.
- R9: `io_m`=0 selects memory and `io_m`=1 selects I/O. The strobes decode as follows: `mem_rd_n` = `rd_n` OR `io_m`, `mem_wr_n` = `wr_n` OR `io_m`, `io_rd_n` = `rd_n` OR NOT `io_m`, and `io_wr_n` = `wr_n` OR NOT `io_m`.
- R10: After T4, if no new `ale` arrives, the bus is idle and `den`, `ad_oe` and `mem_d_oe` are 0. A cycle whose T1 directly follows T4 starts normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one T-state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| ale | input | 1 | Address latch enable, high during T1 |
| cyc_wr | input | 1 | Cycle direction given with `ale`: 1 for write |
| io_m | input | 1 | 1 for an I/O cycle, 0 for a memory cycle |
| rd_n | input | 1 | Processor read strobe, active low |
| wr_n | input | 1 | Processor write strobe, active low |
| ad_i | input | 8 | Shared address/data lines, as driven by the processor |
| ad_o | output | 8 | Read data returned to the shared lines |
| ad_oe | output | 1 | Enable for `ad_o` onto the shared lines |
| a_mid | input | 8 | Dedicated middle address byte |
| a_hi_st | input | 4 | Top address nibble in T1, status afterwards |
| mem_d_i | input | 8 | Data from the memory side |
| mem_d_o | output | 8 | Write data to the memory side |
| mem_d_oe | output | 1 | Enable for `mem_d_o` |
| addr | output | 20 | Demultiplexed address |
| den | output | 1 | Data transfer enable, active high |
| dt_tx | output | 1 | Direction: 1 for transmit (write), 0 for receive |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |

## Verification
Read and write cycles run back to back with addresses 70C12H, FFFFFH and 00000H. All-ones and all-zeros values show any latch bit that is stuck or swapped between nibble and byte. During the data phase, the shared lines and the upper lines carry values deliberately unlike the address. A latch that stays transparent is therefore visible as a changed address. The bench compares `den` in T4 between read and write cycles, which separates the two enable windows. A memory cycle and an I/O cycle driven with the same read/write pins separate the four strobe decodes. An idle stretch after a cycle shows whether the state tracker returns to rest.

// File: rtl/mux_bus_demux_pkg.sv
package mux_bus_demux_pkg;
  typedef enum logic [1:0] {
    TS_IDLE = 2'd0,
    TS_T2   = 2'd1,
    TS_T3   = 2'd2,
    TS_T4   = 2'd3
  } tstate_e;
endpackage

// File: rtl/mux_addr_latch.sv
module mux_addr_latch #(
  parameter int LO_W = 8,
  parameter int HI_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ale,
  input  logic [LO_W-1:0] lo_in,
  input  logic [HI_W-1:0] hi_in,
  output logic [LO_W-1:0] lo_q,
  output logic [HI_W-1:0] hi_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (ale) begin
      lo_q <= lo_in;
      hi_q <= hi_in;
    end
  end

  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (lo_q == $past(lo_in)) && (hi_q == $past(hi_in))); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ale |=> $stable(lo_q) && $stable(hi_q)); // R3
endmodule

// File: rtl/mux_tstate_track.sv
module mux_tstate_track
  import mux_bus_demux_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ale,
  input  logic    cyc_wr,
  output tstate_e state,
  output logic    wr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= TS_IDLE;
      wr_q  <= 1'b0;
    end else if (ale) begin
      state <= TS_T2;
      wr_q  <= cyc_wr;
    end else begin
      unique case (state)
        TS_T2:   state <= TS_T3;
        TS_T3:   state <= TS_T4;
        default: state <= TS_IDLE;
      endcase
    end
  end

  AST_T2_AFTER_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> state == TS_T2); // R5
  AST_IDLE_AFTER_T4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TS_T4 && !ale) |=> state == TS_IDLE); // R10
endmodule

// File: rtl/mux_data_steer.sv
module mux_data_steer
  import mux_bus_demux_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tstate_e           state,
  input  logic              wr_q,
  input  logic              io_m,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [DATA_W-1:0] mem_d_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe,
  output logic [DATA_W-1:0] mem_d_o,
  output logic              mem_d_oe,
  output logic              den,
  output logic              dt_tx,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic              io_rd_n,
  output logic              io_wr_n
);
  logic in_window;

  always_comb begin
    unique case (state)
      TS_T2, TS_T3: in_window = 1'b1;
      TS_T4:        in_window = wr_q;
      default:      in_window = 1'b0;
    endcase
    den      = in_window;
    dt_tx    = wr_q;
    ad_oe    = in_window & ~wr_q;
    mem_d_oe = in_window & wr_q;
    ad_o     = mem_d_i;
    mem_d_o  = ad_i;
    mem_rd_n = rd_n | io_m;
    mem_wr_n = wr_n | io_m;
    io_rd_n  = rd_n | ~io_m;
    io_wr_n  = wr_n | ~io_m;
  end

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    !(ad_oe && mem_d_oe)); // R7
  AST_RD_SPACE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_rd_n && !io_rd_n)); // R9
  AST_WR_T4_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TS_T4 && wr_q) |-> den); // R6
endmodule

// File: rtl/mux_bus_demux.sv
module mux_bus_demux
  import mux_bus_demux_pkg::*;
#(
  parameter int LO_W  = 8,
  parameter int MID_W = 8,
  parameter int HI_W  = 4,
  localparam int ADDR_W = LO_W + MID_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic              cyc_wr,
  input  logic              io_m,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [LO_W-1:0]   ad_i,
  output logic [LO_W-1:0]   ad_o,
  output logic              ad_oe,
  input  logic [MID_W-1:0]  a_mid,
  input  logic [HI_W-1:0]   a_hi_st,
  input  logic [LO_W-1:0]   mem_d_i,
  output logic [LO_W-1:0]   mem_d_o,
  output logic              mem_d_oe,
  output logic [ADDR_W-1:0] addr,
  output logic              den,
  output logic              dt_tx,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic              io_rd_n,
  output logic              io_wr_n
);
  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;
  tstate_e         state;
  logic            wr_q;

  mux_addr_latch #(.LO_W(LO_W), .HI_W(HI_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .ale(ale),
    .lo_in(ad_i), .hi_in(a_hi_st), .lo_q(lo_q), .hi_q(hi_q)
  );

  mux_tstate_track u_track (
    .clk(clk), .rst_n(rst_n), .ale(ale), .cyc_wr(cyc_wr),
    .state(state), .wr_q(wr_q)
  );

  mux_data_steer #(.DATA_W(LO_W)) u_steer (
    .clk(clk), .rst_n(rst_n), .state(state), .wr_q(wr_q),
    .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n),
    .ad_i(ad_i), .mem_d_i(mem_d_i),
    .ad_o(ad_o), .ad_oe(ad_oe), .mem_d_o(mem_d_o), .mem_d_oe(mem_d_oe),
    .den(den), .dt_tx(dt_tx),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n)
  );

  assign addr = {hi_q, a_mid, lo_q};

  AST_MID_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    addr[LO_W+MID_W-1:LO_W] == a_mid); // R4
endmodule

// File: tb/mux_bus_demux_test.sv
`timescale 1ns/1ps
module mux_bus_demux_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ale = 1'b0, cyc_wr = 1'b0, io_m = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] ad_i = 8'h00, a_mid = 8'h00, mem_d_i = 8'h00;
  logic [3:0] a_hi_st = 4'h0;
  logic [7:0] ad_o, mem_d_o;
  logic ad_oe, mem_d_oe, den, dt_tx, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;
  logic [19:0] addr;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mux_bus_demux uut (
    .clk(clk), .rst_n(rst_n), .ale(ale), .cyc_wr(cyc_wr), .io_m(io_m),
    .rd_n(rd_n), .wr_n(wr_n), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
    .a_mid(a_mid), .a_hi_st(a_hi_st), .mem_d_i(mem_d_i), .mem_d_o(mem_d_o),
    .mem_d_oe(mem_d_oe), .addr(addr), .den(den), .dt_tx(dt_tx),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R1: reset values
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    chk("R1 addr in reset", {12'd0, addr}, 32'h0);
    chk("R1 den/dt/oe in reset", {28'd0, den, dt_tx, ad_oe, mem_d_oe}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk("R1 addr after release", {12'd0, addr}, 32'h0);
    chk("R1 den after release", {31'd0, den}, 32'h0);
  endtask

  // Full bus cycle starting at the next falling edge (T1); returns at T4 falling edge.
  task automatic t_cycle(input logic wr, input logic iom, input logic [19:0] a,
                         input logic [7:0] data, input logic [19:0] prev_a);
    @(negedge clk);
    ale = 1'b1; cyc_wr = wr; io_m = iom;
    ad_i = a[7:0]; a_mid = a[15:8]; a_hi_st = a[19:16];
    #2;
    // T1: previous address still held, new middle byte passes
    chk("R3 hold during T1", {12'd0, addr[19:16], addr[7:0]}, {12'd0, prev_a[19:16], prev_a[7:0]});
    chk("R4 mid passthrough", {24'd0, addr[15:8]}, {24'd0, a[15:8]});
    @(negedge clk); // T2
    ale = 1'b0; a_hi_st = ~a[19:16];
    ad_i = wr ? data : ~a[7:0];
    mem_d_i = wr ? 8'h00 : data;
    rd_n = wr; wr_n = ~wr;
    #2;
    chk("R2 latched address", {12'd0, addr}, {12'd0, a});
    chk(wr ? "R6 den/dt T2" : "R5 den/dt T2", {30'd0, den, dt_tx}, {30'd0, 1'b1, wr});
    if (wr) begin
      chk("R8 write path", {22'd0, mem_d_oe, ad_oe, mem_d_o}, {22'd0, 1'b1, 1'b0, data});
    end else begin
      chk("R7 read path", {22'd0, ad_oe, mem_d_oe, ad_o}, {22'd0, 1'b1, 1'b0, data});
    end
    chk("R9 strobes", {28'd0, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n},
        {28'd0, wr | iom, ~wr | iom, wr | ~iom, ~wr | ~iom});
    @(negedge clk); // T3
    ad_i = 8'hC3; a_hi_st = 4'h9;
    if (wr) ad_i = data;
    #2;
    chk("R3 hold during T3", {12'd0, addr}, {12'd0, a});
    chk(wr ? "R6 den T3" : "R5 den T3", {31'd0, den}, 32'd1);
    @(negedge clk); // T4
    rd_n = 1'b1; wr_n = 1'b1; a_hi_st = 4'h6; ad_i = 8'h3C;
    #2;
    chk("R3 hold during T4", {12'd0, addr}, {12'd0, a});
    chk(wr ? "R6 den T4" : "R5 den T4", {31'd0, den}, {31'd0, wr});
  endtask

  // R10: idle after T4, latch untouched by line activity
  task automatic t_idle(input logic [19:0] a);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      ad_i = 8'h11 * i[7:0]; a_hi_st = i[3:0] + 4'h3;
      #2;
      chk("R10 idle den/oe", {29'd0, den, ad_oe, mem_d_oe}, 32'd0);
      chk("R3 hold in idle", {12'd0, addr[19:16], addr[7:0]}, {12'd0, a[19:16], a[7:0]});
    end
  endtask

  initial begin
    t_reset();
    t_cycle(1'b0, 1'b0, 20'h70C12, 8'h30, 20'h00000);
    t_cycle(1'b1, 1'b0, 20'hFFFFF, 8'hA5, 20'h70C12);
    t_cycle(1'b0, 1'b0, 20'h00000, 8'hFF, 20'hFFFFF);
    t_cycle(1'b0, 1'b1, 20'h5A3C6, 8'h81, 20'h00000);
    t_cycle(1'b1, 1'b1, 20'hA5C39, 8'h7E, 20'h5A3C6);
    t_idle(20'hA5C39);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule